// File: doc/BRIEF.md
# Sequence Streamer Control and Status Registers

This block is the software-facing register file that sits beside a sequence streamer core on a single clock. Software uses a small memory-mapped bus to stop the streamer, enable and force its trigger, reset the trigger logic or the whole core, and ask it to halt on a buffer error. It reads back buffer-error, done, triggered and armed flags. The trigger latch and the run qualifier are kept here so that the core sees one clean "run" signal.

The block also owns the output path. An override word can replace the streamer's data output through a multiplexer. Software writes go to a shadow copy of the select bit and the override word. The active copy that drives the multiplexer takes the shadow only while the streamer reports idle, or in the cycle of a core-reset pulse, so the output never switches in the middle of a running sequence. Two one-cycle-delayed snapshots, one taken before the multiplexer and one after, are readable on the bus.

Top module: `strm_regs_top`

## Requirements
- R1: After reset every control output is 0, triggered and armed are 0, and qOut follows streamQIn.
- R2: A write to address 0x00 stores stop (bit 0), trigger enable (bit 2), output select (bit 5) and stop-on-buffer-error (bit 6). These bits read back at the same positions and drive stopOut, trigEnOut and stopOnBufErrOut.
- R3: Bit 1 (trigger force), bit 4 (trigger reset) and bit 3 (core reset) of a control write each raise their output for exactly the one cycle after the write, and they always read back as 0.
- R4: trigIn sets the triggered latch only while trigger enable (bit 2) or extTrigEnIn is 1. A trigger force sets the latch regardless of enable. A trigger reset or a core reset clears it.
- R5: Status at address 0x04 reads buffer error at bit 0, done at bit 1, triggered at bit 2 and armed at bit 3. Armed is 1 when the trigger is enabled and not yet triggered. Writes to 0x04 change nothing.
- R6: A control write with bit 3 set leaves the whole control register at 0, pulses coreRstOut and clears the triggered latch.
- R7: A write to address 0x08 stores the override word and sets the output-select bit in the control register.
- R8: The active select and override word take their shadow values only on a clock edge where streamIdleIn is 1 or coreRstOut is 1. qOut is the active override word when the active select is 1, otherwise streamQIn.
- R9: Address 0x0C reads qOut and address 0x10 reads streamQIn, each as sampled on the previous clock edge.
- R10: runOut is 1 only when triggered, stop is 0, gateIn is 1, no core reset is pulsing, and not (stop-on-buffer-error and bufErrIn).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus byte address |
| wrData | input | 32 | Bus write data |
| rdData | output | 32 | Bus read data, combinational from addr |
| trigIn | input | 1 | Trigger event from the core |
| extTrigEnIn | input | 1 | External trigger enable pin |
| gateIn | input | 1 | External output-enable gate; 0 pauses streaming |
| bufErrIn | input | 1 | Buffer error flag from the core |
| doneIn | input | 1 | Sequence done flag from the core |
| streamIdleIn | input | 1 | Streamer is idle |
| streamQIn | input | DATA_W | Streamer data output |
| qOut | output | DATA_W | Output word after the override multiplexer |
| outSelOut | output | 1 | Active output-select value |
| stopOut | output | 1 | Stop request |
| trigEnOut | output | 1 | Software trigger enable |
| trigForceOut | output | 1 | One-cycle trigger force pulse |
| trigResetOut | output | 1 | One-cycle trigger reset pulse |
| coreRstOut | output | 1 | One-cycle core reset pulse |
| stopOnBufErrOut | output | 1 | Stop-on-buffer-error setting |
| triggeredOut | output | 1 | Triggered latch |
| armedOut | output | 1 | Trigger enabled and waiting |
| runOut | output | 1 | Streaming permitted this cycle |

## Verification
The bench drives control writes while the streamer is busy and checks that qOut does not move until idle is raised or a core reset pulses. A design that committed at once would glitch the output mid-sequence. It raises trigIn with both enables low and expects no triggered latch; a design that left the gate off would trigger early. Pulse bits are read back after being written, and a stored pulse would make force or reset repeat. Random stimulus mixes override writes, select writes and idle toggles against a reference model of the shadow and active copies, and it checks both snapshots for a one-edge lag.

// File: rtl/strm_regs_pkg.sv
package strm_regs_pkg;
  localparam int BUS_W = 32;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_OVR  = 'h08;
  localparam int OFF_POST = 'h0C;
  localparam int OFF_PRE  = 'h10;

  // control bit positions
  localparam int B_STOP   = 0;
  localparam int B_FORCE  = 1;
  localparam int B_TRIGEN = 2;
  localparam int B_CRST   = 3;
  localparam int B_TRST   = 4;
  localparam int B_OSEL   = 5;
  localparam int B_SOBE   = 6;

  // status bit positions
  localparam int S_BUFERR = 0;
  localparam int S_DONE   = 1;
  localparam int S_TRIG   = 2;
  localparam int S_ARMED  = 3;

  typedef struct packed {
    logic ovrWr;      // override word write this cycle
    logic selShadow;  // shadow output-select bit
    logic commitOk;   // active copy may take the shadow
  } outStrobe_t;
endpackage

// File: rtl/strm_ctrl_regs.sv
module strm_ctrl_regs
  import strm_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wrData,
  input  logic                trigIn,
  input  logic                extTrigEnIn,
  input  logic                gateIn,
  input  logic                bufErrIn,
  input  logic                doneIn,
  input  logic                streamIdleIn,
  output logic [BUS_W-1:0]    ctrlRd,
  output logic [BUS_W-1:0]    statRd,
  output logic                stopOut,
  output logic                trigEnOut,
  output logic                trigForceOut,
  output logic                trigResetOut,
  output logic                coreRstOut,
  output logic                stopOnBufErrOut,
  output logic                triggeredOut,
  output logic                armedOut,
  output logic                runOut,
  output outStrobe_t          strb
);
  logic ctrlWr, ovrWr;
  logic stopR, trigEnR, oselR, sobeR;
  logic forceP, trstP, crstP;
  logic trigSeen, effEn;
  logic [BUS_W-1:0] unusedBits;

  assign unusedBits = wrData;
  assign ctrlWr = wrEn && (addr == ADDR_W'(OFF_CTRL));
  assign ovrWr  = wrEn && (addr == ADDR_W'(OFF_OVR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopR   <= 1'b0;
      trigEnR <= 1'b0;
      oselR   <= 1'b0;
      sobeR   <= 1'b0;
      forceP  <= 1'b0;
      trstP   <= 1'b0;
      crstP   <= 1'b0;
    end else begin
      forceP <= ctrlWr && wrData[B_FORCE];
      trstP  <= ctrlWr && wrData[B_TRST];
      crstP  <= ctrlWr && wrData[B_CRST];
      if (ctrlWr && wrData[B_CRST]) begin
        stopR   <= 1'b0;
        trigEnR <= 1'b0;
        oselR   <= 1'b0;
        sobeR   <= 1'b0;
      end else if (ctrlWr) begin
        stopR   <= wrData[B_STOP];
        trigEnR <= wrData[B_TRIGEN];
        oselR   <= wrData[B_OSEL];
        sobeR   <= wrData[B_SOBE];
      end else if (ovrWr) begin
        oselR <= 1'b1;
      end
    end
  end

  assign effEn = trigEnR || extTrigEnIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigSeen <= 1'b0;
    end else if (crstP || trstP) begin
      trigSeen <= 1'b0;
    end else if (forceP || (trigIn && effEn)) begin
      trigSeen <= 1'b1;
    end
  end

  always_comb begin
    ctrlRd = '0;
    ctrlRd[B_STOP]   = stopR;
    ctrlRd[B_TRIGEN] = trigEnR;
    ctrlRd[B_OSEL]   = oselR;
    ctrlRd[B_SOBE]   = sobeR;
    statRd = '0;
    statRd[S_BUFERR] = bufErrIn;
    statRd[S_DONE]   = doneIn;
    statRd[S_TRIG]   = trigSeen;
    statRd[S_ARMED]  = armedOut;
  end

  assign stopOut         = stopR;
  assign trigEnOut       = trigEnR;
  assign trigForceOut    = forceP;
  assign trigResetOut    = trstP;
  assign coreRstOut      = crstP;
  assign stopOnBufErrOut = sobeR;
  assign triggeredOut    = trigSeen;
  assign armedOut        = effEn && !trigSeen;
  assign runOut          = trigSeen && !stopR && gateIn && !crstP && !(sobeR && bufErrIn);

  assign strb.ovrWr     = ovrWr;
  assign strb.selShadow = oselR;
  assign strb.commitOk  = streamIdleIn || crstP;
endmodule

// File: rtl/strm_out_path.sv
module strm_out_path
  import strm_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  outStrobe_t        strb,
  input  logic [DATA_W-1:0] wrWord,
  input  logic [DATA_W-1:0] streamQIn,
  output logic [DATA_W-1:0] qOut,
  output logic              outSelOut,
  output logic [DATA_W-1:0] postSnap,
  output logic [DATA_W-1:0] preSnap
);
  logic [DATA_W-1:0] shadowVal, activeVal;
  logic              activeSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowVal <= '0;
    end else if (strb.ovrWr) begin
      shadowVal <= wrWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSel <= 1'b0;
      activeVal <= '0;
    end else if (strb.commitOk) begin
      activeSel <= strb.selShadow;
      activeVal <= shadowVal;
    end
  end

  assign qOut      = activeSel ? activeVal : streamQIn;
  assign outSelOut = activeSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postSnap <= '0;
      preSnap  <= '0;
    end else begin
      postSnap <= qOut;
      preSnap  <= streamQIn;
    end
  end
endmodule

// File: rtl/strm_regs_top.sv
module strm_regs_top
  import strm_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              trigIn,
  input  logic              extTrigEnIn,
  input  logic              gateIn,
  input  logic              bufErrIn,
  input  logic              doneIn,
  input  logic              streamIdleIn,
  input  logic [DATA_W-1:0] streamQIn,
  output logic [DATA_W-1:0] qOut,
  output logic              outSelOut,
  output logic              stopOut,
  output logic              trigEnOut,
  output logic              trigForceOut,
  output logic              trigResetOut,
  output logic              coreRstOut,
  output logic              stopOnBufErrOut,
  output logic              triggeredOut,
  output logic              armedOut,
  output logic              runOut
);
  outStrobe_t        strb;
  logic [BUS_W-1:0]  ctrlRd, statRd;
  logic [DATA_W-1:0] postSnap, preSnap;

  strm_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .trigIn(trigIn), .extTrigEnIn(extTrigEnIn), .gateIn(gateIn),
    .bufErrIn(bufErrIn), .doneIn(doneIn), .streamIdleIn(streamIdleIn),
    .ctrlRd(ctrlRd), .statRd(statRd),
    .stopOut(stopOut), .trigEnOut(trigEnOut), .trigForceOut(trigForceOut),
    .trigResetOut(trigResetOut), .coreRstOut(coreRstOut),
    .stopOnBufErrOut(stopOnBufErrOut), .triggeredOut(triggeredOut),
    .armedOut(armedOut), .runOut(runOut), .strb(strb)
  );

  strm_out_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .wrWord(wrData[DATA_W-1:0]),
    .streamQIn(streamQIn), .qOut(qOut), .outSelOut(outSelOut),
    .postSnap(postSnap), .preSnap(preSnap)
  );

  always_comb begin
    case (addr)
      ADDR_W'(OFF_CTRL): rdData = ctrlRd;
      ADDR_W'(OFF_STAT): rdData = statRd;
      ADDR_W'(OFF_POST): rdData = BUS_W'(postSnap);
      ADDR_W'(OFF_PRE):  rdData = BUS_W'(preSnap);
      default:           rdData = '0;
    endcase
  end
endmodule

// File: rtl/strm_regs_chk.sv
module strm_regs_chk (
  input logic clk,
  input logic rstN,
  input logic trigIn,
  input logic extTrigEnIn,
  input logic trigEnOut,
  input logic trigForceOut,
  input logic trigResetOut,
  input logic coreRstOut,
  input logic stopOut,
  input logic stopOnBufErrOut,
  input logic bufErrIn,
  input logic streamIdleIn,
  input logic outSelOut,
  input logic triggeredOut,
  input logic runOut
);
  // R4
  trig_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(triggeredOut) |-> $past(trigForceOut || (trigIn && (trigEnOut || extTrigEnIn))));

  // R4
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigResetOut |=> !triggeredOut);

  // R6
  core_rst_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreRstOut |-> (!stopOut && !trigEnOut && !stopOnBufErrOut));

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!streamIdleIn) && $past(!coreRstOut)) |-> $stable(outSelOut));

  // R10
  buf_err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopOnBufErrOut && bufErrIn) |-> !runOut);
endmodule

bind strm_regs_top strm_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .extTrigEnIn(extTrigEnIn),
  .trigEnOut(trigEnOut), .trigForceOut(trigForceOut), .trigResetOut(trigResetOut),
  .coreRstOut(coreRstOut), .stopOut(stopOut), .stopOnBufErrOut(stopOnBufErrOut),
  .bufErrIn(bufErrIn), .streamIdleIn(streamIdleIn), .outSelOut(outSelOut),
  .triggeredOut(triggeredOut), .runOut(runOut)
);

// File: tb/tb_strm_regs_top.sv
module tb_strm_regs_top;
  localparam int PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic trigIn = 0, extTrigEnIn = 0, gateIn = 1, bufErrIn = 0, doneIn = 0, streamIdleIn = 0;
  logic [DW-1:0] streamQIn = '0, qOut;
  logic outSelOut, stopOut, trigEnOut, trigForceOut, trigResetOut, coreRstOut;
  logic stopOnBufErrOut, triggeredOut, armedOut, runOut;

  int nChk = 0, nFail = 0;

  // reference model of shadow and active output copies
  logic mShSel = 0, mActSel = 0, mRstP = 0;
  logic [DW-1:0] mShVal = '0, mActVal = '0;

  always #(PERIOD/2) clk = ~clk;

  strm_regs_top #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  always @(posedge clk) begin
    if (!rstN) begin
      mShSel = 0; mActSel = 0; mShVal = '0; mActVal = '0; mRstP = 0;
    end else begin
      if (streamIdleIn || mRstP) begin mActSel = mShSel; mActVal = mShVal; end
      if (wrEn && addr == 5'h08) begin mShVal = wrData; mShSel = 1; end
      else if (wrEn && addr == 5'h00) mShSel = wrData[3] ? 1'b0 : wrData[5];
      mRstP = wrEn && addr == 5'h00 && wrData[3];
    end
  end

  function automatic logic [DW-1:0] expQ(logic [DW-1:0] s);
    return mActSel ? mActVal : s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0; addr = 5'h1C;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData; addr = 5'h1C;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    nFail++; nChk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [31:0] r, pv, ps;
    logic [31:0] seed;
    seed = $urandom(32'd4711);
    streamQIn = 32'hA5A5_0F0F;
    cyc(3); rstN = 1; cyc(1);
    // R1 reset state
    chk("R1 stop", stopOut, 0); chk("R1 trigEn", trigEnOut, 0);
    chk("R1 triggered", triggeredOut, 0); chk("R1 armed", armedOut, 0);
    chk("R1 qOut", qOut, streamQIn);
    rd(5'h00, r); chk("R1 ctrl", r, 0);
    // R2 control bits, streamer busy
    wr(5'h00, 32'h65);
    rd(5'h00, r); chk("R2 ctrl readback", r, 32'h65);
    chk("R2 stopOut", stopOut, 1); chk("R2 trigEnOut", trigEnOut, 1);
    chk("R2 sobe", stopOnBufErrOut, 1);
    chk("R5 armed when enabled", armedOut, 1);
    // R8 no commit while busy
    cyc(3); chk("R8 busy holds", qOut, streamQIn);
    streamIdleIn = 1; cyc(2); chk("R8 idle commits", qOut, 0);
    // R3 force pulse
    wr(5'h00, 32'h67);
    chk("R3 force high", trigForceOut, 1);
    cyc(1); chk("R3 force low", trigForceOut, 0);
    chk("R4 force sets", triggeredOut, 1); chk("R5 armed off", armedOut, 0);
    rd(5'h00, r); chk("R3 pulse reads 0", r, 32'h65);
    // R4 trigger reset
    wr(5'h00, 32'h75);
    chk("R3 trst high", trigResetOut, 1);
    cyc(1); chk("R4 trst clears", triggeredOut, 0); chk("R3 trst low", trigResetOut, 0);
    wr(5'h00, 32'h61);
    trigIn = 1; cyc(2); chk("R4 disabled ignores", triggeredOut, 0);
    extTrigEnIn = 1; cyc(1); chk("R4 ext enable", triggeredOut, 1);
    trigIn = 0; extTrigEnIn = 0;
    // R5 status
    bufErrIn = 1; doneIn = 1;
    rd(5'h04, r); chk("R5 status", r, 32'h7);
    wr(5'h04, 32'h0);
    rd(5'h04, r); chk("R5 write ignored", r, 32'h7);
    // R10 run qualifier
    chk("R10 stop blocks", runOut, 0);
    streamIdleIn = 0;
    wr(5'h00, 32'h40);
    chk("R10 buferr blocks", runOut, 0);
    bufErrIn = 0; #1 chk("R10 run", runOut, 1);
    gateIn = 0; #1 chk("R10 gate", runOut, 0);
    gateIn = 1;
    // R6 core reset; active select still 1 from earlier
    chk("R8 select held busy", outSelOut, 1);
    wr(5'h00, 32'h6D);
    chk("R6 coreRst pulse", coreRstOut, 1);
    rd(5'h00, r); chk("R6 ctrl zero", r, 0);
    cyc(1); chk("R6 triggered clear", triggeredOut, 0);
    chk("R6 qOut via reset commit", qOut, streamQIn);
    // R7 override write
    streamIdleIn = 1;
    wr(5'h08, 32'h1234_5678);
    rd(5'h00, r); chk("R7 sel bit set", r, 32'h20);
    cyc(1); chk("R7 qOut override", qOut, 32'h1234_5678);
    // R9 snapshots
    streamQIn = 32'hCAFE_0001; cyc(1);
    rd(5'h10, r); chk("R9 pre snap", r, 32'hCAFE_0001);
    rd(5'h0C, r); chk("R9 post snap", r, 32'h1234_5678);
    // random mix
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      pv = streamQIn; ps = qOut;
      streamQIn = $urandom; streamIdleIn = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: begin wrEn = 1; addr = 5'h08; wrData = $urandom; end
        1: begin wrEn = 1; addr = 5'h00; wrData = {26'd0, 1'($urandom_range(0,1)), 5'd0}; end
        default: begin wrEn = 0; addr = 5'h1C; end
      endcase
      @(negedge clk);
      wrEn = 0;
      chk("R8 random qOut", qOut, expQ(streamQIn));
      rd(5'h10, r); chk("R9 random pre", r, streamQIn);
    end
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule